// File: doc/BRIEF.md
# NOR Flash Command Decoder with Device-ID Readout

This block stands in for the command interface of a 16-bit NOR flash bank that sits at a fixed byte address in a larger memory map. The bus presents a byte address, a write strobe, a read strobe and write data. The block converts each in-window byte address into a word offset by subtracting the bank base and halving the result. It then watches the write stream for the three-write unlock-and-identify sequence. When that sequence completes, the read path switches from a small stub array to an identification register.

While the bank is in identify mode, one fixed word offset returns the device ID and every other offset reads as zero. Writing the reset command at the bank base puts the bank back into array mode. Programming, erasing and protection commands are not modelled. Array reads return words from a computed stub table, so software that probes the ID can be run against the model.

Top module: `nor_id_responder`

## Requirements
- R1: After reset, mode_id is 0, rd_data is 0x0000 and the command decoder is at its first step.
- R2: The bank window covers byte addresses BASE_ADDR through BASE_ADDR + 2^(OFF_W+1) - 1, and BASE_ADDR is aligned to that size. The word offset of an access is (byte address - BASE_ADDR) / 2. A read outside the window returns 0x0000. A write outside the window changes neither the mode nor the sequence progress.
- R3: The identify sequence is three in-window writes in this order: data 0x00AA at offset 0x555, then 0x0055 at offset 0x2AA, then 0x0090 at offset 0x555. mode_id reads 1 in the cycle after the third write.
- R4: In identify mode, a read at offset ID_OFF (default 0xE) returns DEV_ID (default 0x223D).
- R5: In identify mode, a read at any other in-window offset returns 0x0000.
- R6: In array mode, a read at offset k returns STUB_SEED + STUB_STEP * (k mod STUB_WORDS), truncated to 16 bits. The defaults are 0x1200, 0x0111 and 16.
- R7: An in-window write that does not match the expected step sends the decoder back to the first step and leaves mode_id unchanged. A later matching step counts only once the sequence has been restarted from its first write.
- R8: Writing 0x00F0 at offset 0 sets mode_id to 0 in the next cycle. Any other write leaves identify mode in place, including 0x00F0 written at a nonzero offset.
- R9: Read data is registered. rd_data takes its new value in the cycle after rd_en and keeps it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| wr_data | input | 16 | Write data (command value) |
| rd_data | output | 16 | Registered read data |
| mode_id | output | 1 | 1 in identify mode, 0 in array mode |

## Verification
The assertions check on every cycle that a completed sequence sets the mode and that the reset command clears it. They also check that a broken step leaves the mode alone, that identify-mode reads return the ID or zero, that out-of-window reads return zero and that idle cycles hold the read data. Some behaviour only the bench's scenarios can show. These are the exact stub values in array mode, the restart from the first step after a broken sequence, and that out-of-window writes placed in the middle of a valid sequence leave it intact. The bench also shows that identify mode survives stray writes, including 0x00F0 at a nonzero offset.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GOT_A = 2'd1,
    SEQ_GOT_B = 2'd2
  } seq_t;

  localparam logic [15:0] CMD_UNLOCK_A = 16'h00AA;
  localparam logic [15:0] CMD_UNLOCK_B = 16'h0055;
  localparam logic [15:0] CMD_IDENTIFY = 16'h0090;
  localparam logic [15:0] CMD_RESET    = 16'h00F0;

  localparam logic [31:0] OFF_UNLOCK_A = 32'h0000_0555;
  localparam logic [31:0] OFF_UNLOCK_B = 32'h0000_02AA;
  localparam logic [31:0] OFF_RESET    = 32'h0000_0000;

  // Byte address falls inside the bank window.
  function automatic logic bank_hit(logic [31:0] byte_addr, logic [31:0] base,
                                    logic [31:0] win_bytes);
    return (byte_addr >= base) && ((byte_addr - base) < win_bytes);
  endfunction

  // Word offset of a byte address relative to the bank base.
  function automatic logic [31:0] word_off(logic [31:0] byte_addr, logic [31:0] base);
    return (byte_addr - base) >> 1;
  endfunction

  // Stub array content at a given index.
  function automatic logic [15:0] stub_word(logic [31:0] idx, logic [15:0] seed,
                                            logic [15:0] step);
    logic [15:0] prod;
    prod = 16'(idx) * step;
    return seed + prod;
  endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_id_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] off,
  input  logic [15:0] wr_data,
  output logic        enter_id,
  output logic        exit_cmd,
  output logic        seq_break
);

  seq_t state_q, state_d;
  logic step_ok;

  always_comb begin
    step_ok = 1'b0;
    case (state_q)
      SEQ_IDLE:  step_ok = (off == OFF_UNLOCK_A) && (wr_data == CMD_UNLOCK_A);
      SEQ_GOT_A: step_ok = (off == OFF_UNLOCK_B) && (wr_data == CMD_UNLOCK_B);
      SEQ_GOT_B: step_ok = (off == OFF_UNLOCK_A) && (wr_data == CMD_IDENTIFY);
      default:   step_ok = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (wr_hit) begin
      if (!step_ok) begin
        state_d = SEQ_IDLE;
      end else begin
        case (state_q)
          SEQ_IDLE:  state_d = SEQ_GOT_A;
          SEQ_GOT_A: state_d = SEQ_GOT_B;
          default:   state_d = SEQ_IDLE;
        endcase
      end
    end
  end

  assign enter_id  = wr_hit && step_ok && (state_q == SEQ_GOT_B);
  assign exit_cmd  = wr_hit && (off == OFF_RESET) && (wr_data == CMD_RESET);
  assign seq_break = wr_hit && !step_ok && (state_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/nor_read_path.sv
module nor_read_path
  import nor_id_pkg::*;
#(
  parameter int unsigned STUB_WORDS = 16,
  parameter logic [15:0] STUB_SEED  = 16'h1200,
  parameter logic [15:0] STUB_STEP  = 16'h0111,
  parameter logic [15:0] DEV_ID     = 16'h223D,
  localparam int unsigned STUB_AW   = (STUB_WORDS > 1) ? $clog2(STUB_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               in_bank,
  input  logic               mode_id,
  input  logic               id_sel,
  input  logic [STUB_AW-1:0] stub_idx,
  output logic [15:0]        rd_data
);

  logic [15:0] stub_rom [STUB_WORDS];
  logic [15:0] rd_next;

  for (genvar g = 0; g < STUB_WORDS; g++) begin : g_stub
    assign stub_rom[g] = stub_word(32'(g), STUB_SEED, STUB_STEP);
  end

  always_comb begin
    if (!in_bank)     rd_next = 16'h0000;
    else if (mode_id) rd_next = id_sel ? DEV_ID : 16'h0000;
    else              rd_next = stub_rom[stub_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 16'h0000;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/nor_id_responder.sv
module nor_id_responder
  import nor_id_pkg::*;
#(
  parameter int unsigned ADDR_W     = 28,
  parameter logic [31:0] BASE_ADDR  = 32'h0900_0000,
  parameter int unsigned OFF_W      = 12,
  parameter logic [15:0] DEV_ID     = 16'h223D,
  parameter logic [31:0] ID_OFF     = 32'h0000_000E,
  parameter int unsigned STUB_WORDS = 16,
  parameter logic [15:0] STUB_SEED  = 16'h1200,
  parameter logic [15:0] STUB_STEP  = 16'h0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              mode_id
);

  localparam logic [31:0] WIN_BYTES = 32'(1) << (OFF_W + 1);
  localparam int unsigned STUB_AW   = (STUB_WORDS > 1) ? $clog2(STUB_WORDS) : 1;

  logic [31:0] addr32;
  logic [31:0] off;
  logic        in_bank;
  logic        wr_hit;
  logic        enter_id;
  logic        exit_cmd;
  logic        seq_break;
  logic        mode_q;

  assign addr32  = {{(32 - ADDR_W){1'b0}}, bus_addr};
  assign in_bank = bank_hit(addr32, BASE_ADDR, WIN_BYTES);
  assign off     = word_off(addr32, BASE_ADDR);
  assign wr_hit  = wr_en && in_bank;

  nor_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .off       (off),
    .wr_data   (wr_data),
    .enter_id  (enter_id),
    .exit_cmd  (exit_cmd),
    .seq_break (seq_break)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (exit_cmd) mode_q <= 1'b0;
    else if (enter_id) mode_q <= 1'b1;
  end

  assign mode_id = mode_q;

  nor_read_path #(
    .STUB_WORDS (STUB_WORDS),
    .STUB_SEED  (STUB_SEED),
    .STUB_STEP  (STUB_STEP),
    .DEV_ID     (DEV_ID)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .in_bank  (in_bank),
    .mode_id  (mode_q),
    .id_sel   (off == ID_OFF),
    .stub_idx (off[STUB_AW-1:0]),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/nor_id_checker.sv
module nor_id_checker
  import nor_id_pkg::*;
#(
  parameter int unsigned ADDR_W    = 28,
  parameter logic [31:0] BASE_ADDR = 32'h0900_0000,
  parameter int unsigned OFF_W     = 12,
  parameter logic [15:0] DEV_ID    = 16'h223D,
  parameter logic [31:0] ID_OFF    = 32'h0000_000E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       rd_data,
  input logic              mode_id,
  input logic              enter_id,
  input logic              exit_cmd,
  input logic              seq_break
);

  localparam logic [31:0] WIN_BYTES = 32'(1) << (OFF_W + 1);

  logic [31:0] a32;
  logic        hit;
  logic        at_id;
  assign a32   = {{(32 - ADDR_W){1'b0}}, bus_addr};
  assign hit   = bank_hit(a32, BASE_ADDR, WIN_BYTES);
  assign at_id = word_off(a32, BASE_ADDR) == ID_OFF;

  // R3
  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_id |=> mode_id);
  // R8
  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_cmd |=> !mode_id);
  // R7
  p_break_keeps_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_break && !exit_cmd) |=> $stable(mode_id));
  // R4
  p_id_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && mode_id && at_id) |=> (rd_data == DEV_ID));
  // R5
  p_id_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && mode_id && !at_id) |=> (rd_data == 16'h0000));
  // R2
  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rd_data == 16'h0000));
  // R9
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (!mode_id && rd_data == 16'h0000);
    end
  end

endmodule

bind nor_id_responder nor_id_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .OFF_W     (OFF_W),
  .DEV_ID    (DEV_ID),
  .ID_OFF    (ID_OFF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .bus_addr  (bus_addr),
  .rd_data   (rd_data),
  .mode_id   (mode_id),
  .enter_id  (enter_id),
  .exit_cmd  (exit_cmd),
  .seq_break (seq_break)
);

// File: tb/test_nor_id_responder.sv
module test_nor_id_responder;

  localparam logic [27:0] BASE = 28'h900_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [27:0] bus_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        mode_id;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_id_responder i_nor_id_responder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .mode_id(mode_id)
  );

  // Array content expected from the requirement formula.
  function automatic logic [15:0] exp_stub(int k);
    int v;
    v = 'h1200 + 'h0111 * (k % 16);
    return v[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_abs(logic [27:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; bus_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(int off, logic [15:0] d);
    wr_abs(BASE + 28'(2 * off), d);
  endtask

  task automatic rd_abs(logic [27:0] a, output logic [15:0] q);
    @(negedge clk);
    rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic rd(int off, output logic [15:0] q);
    rd_abs(BASE + 28'(2 * off), q);
  endtask

  task automatic enter_seq();
    wr('h555, 16'h00AA);
    wr('h2AA, 16'h0055);
    wr('h555, 16'h0090);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mode after reset", 16'(mode_id), 16'h0);
    check("R1 rd_data after reset", rd_data, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_array_reads();
    logic [15:0] q;
    rd(0, q);     check("R6 array off 0", q, exp_stub(0));
    rd(3, q);     check("R6 array off 3", q, exp_stub(3));
    rd('hE, q);   check("R6 array off E", q, exp_stub('hE));
    rd('h555, q); check("R6 array off 555", q, exp_stub('h555));
    repeat (3) @(negedge clk);
    check("R9 rd_data held while idle", rd_data, exp_stub('h555));
  endtask

  task automatic t_enter_and_read();
    logic [15:0] q;
    enter_seq();
    check("R3 mode after sequence", 16'(mode_id), 16'h1);
    rd('hE, q);   check("R4 device id", q, 16'h223D);
    rd(5, q);     check("R5 other offset zero", q, 16'h0000);
    rd('h555, q); check("R5 offset 555 zero", q, 16'h0000);
    wr(0, 16'h00AA);
    check("R8 stray write keeps id mode", 16'(mode_id), 16'h1);
    wr(1, 16'h00F0);
    check("R8 F0 at offset 1 keeps id mode", 16'(mode_id), 16'h1);
    rd('hE, q);   check("R4 id still readable", q, 16'h223D);
  endtask

  task automatic t_exit();
    logic [15:0] q;
    wr(0, 16'h00F0);
    check("R8 reset command leaves id mode", 16'(mode_id), 16'h0);
    rd('hE, q);   check("R6 array read after exit", q, exp_stub('hE));
  endtask

  task automatic t_broken();
    logic [15:0] q;
    wr('h555, 16'h00AA); wr('h2AA, 16'h0055); wr('h554, 16'h0090);
    check("R7 wrong final offset", 16'(mode_id), 16'h0);
    wr('h555, 16'h00AA); wr('h2AA, 16'h0012); wr('h2AA, 16'h0055); wr('h555, 16'h0090);
    check("R7 restart required after break", 16'(mode_id), 16'h0);
    wr('h555, 16'h00AA); wr('h2AA, 16'h0055); wr('h555, 16'h0091);
    check("R7 wrong final data", 16'(mode_id), 16'h0);
    rd(3, q); check("R7 array still served", q, exp_stub(3));
  endtask

  task automatic t_outside();
    logic [15:0] q;
    logic [27:0] far;
    far = BASE + 28'h10_0000;
    wr_abs(far + 28'(2 * 'h555), 16'h00AA);
    wr_abs(far + 28'(2 * 'h2AA), 16'h0055);
    wr_abs(far + 28'(2 * 'h555), 16'h0090);
    check("R2 sequence outside window ignored", 16'(mode_id), 16'h0);
    rd_abs(BASE - 28'h2, q);
    check("R2 read below window zero", q, 16'h0000);
    rd_abs(far, q);
    check("R2 read above window zero", q, 16'h0000);
    wr('h555, 16'h00AA);
    wr_abs(far, 16'h1234);
    wr('h2AA, 16'h0055);
    wr_abs(BASE - 28'h2, 16'h00F0);
    wr('h555, 16'h0090);
    check("R2 outside writes do not break sequence", 16'(mode_id), 16'h1);
    wr_abs(far, 16'h00F0);
    check("R2 outside reset command ignored", 16'(mode_id), 16'h1);
    wr(0, 16'h00F0);
    check("R8 back to array", 16'(mode_id), 16'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_array_reads();
    t_enter_and_read();
    t_exit();
    t_broken();
    t_outside();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule